// File: doc/BRIEF.md
# Asynchronous Serial Frame Monitor

This block listens passively to one or two asynchronous serial lines, sampled by the system clock, and turns every frame it sees into a stream of tagged event records. Each channel has its own decoder. It waits for the line to fall from its idle level, samples every bit slot at its centre, and reports the start bit, the assembled data word, the parity bit and the stop bit as separate events. It also reports malformed frames as distinct events: a start bit that is not low at its centre, a stop bit that is not high, and a parity mismatch.

Framing is set at run time and is shared by both channels. The settings are the bit period in clock cycles, a data width of 5 to 9 bits, the parity mode, the stop length, the bit order, and two inversion options. One option inverts the whole line, so the line idles low. The other inverts only the data and parity bits. Each channel has its own event outputs, so events from both channels that fall in the same cycle are presented together and need no arbitration.

Top module: `uart_frame_monitor`

## Requirements
- R1: Each line passes through two synchronizer flops. A frame begins only on a high-to-low transition of the synchronized, normalized line. A line that stays at its idle level produces no event, and no event is valid during reset. A valid start bit gives event kind 0.
- R2: With a bit period of P cycles, the start-bit event is valid P/2+3 cycles after the line falls. Each later bit slot k is sampled exactly k×P cycles after the start-bit sample.
- R3: The data width N (5 to 9) is taken from `cfgDataBits`. After the N-th data sample, an event of kind 1 presents the word right-aligned on `evtData`, with the upper bits zero. By default the first bit received is the least significant.
- R4: Parity modes are encoded as 0 none, 1 odd, 2 even, 3 mark (bit must be 1) and 4 space (bit must be 0). Odd and even count the ones over the data plus the parity bit. The parity sample gives kind 2 when it matches and kind 6 when it does not. Either event carries the expected bit on `evtParExp` and the received bit on `evtParGot`.
- R5: With parity mode 0 there is no parity slot. The stop slot follows the last data bit directly.
- R6: A start bit that is high at its centre gives event kind 4. The channel then drops the frame and waits for the next falling edge.
- R7: A stop sample that is high gives kind 3, and a low stop sample gives kind 5. In both cases the channel returns to idle and edge detection is rearmed.
- R8: The stop length is encoded as 0 half, 1 one and 2 one-and-a-half bit periods. The stop slot is sampled at P/4, P/2 or 3P/4 into the slot respectively.
- R9: When `cfgMsbFirst` is 1, the first data bit received is the most significant bit of the N-bit word.
- R10: When `cfgLineInvert` is 1, the whole line is inverted: it idles low, and its start bit is high.
- R11: When `cfgDataInvert` is 1, only the data and parity bits are inverted on the line. The start and stop bits keep their normal levels.
- R12: The channels are decoded independently. Channel 0 (receive) tags its events 0 on `evtChan`, and channel 1 (transmit) tags its events 1. Traffic on one channel causes no event on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | NUM_CH | Serial lines, index 0 receive, index 1 transmit |
| cfgBitPeriod | input | CNT_W | Bit period in clock cycles |
| cfgDataBits | input | 4 | Data width, 5 to 9 |
| cfgParity | input | 3 | Parity mode |
| cfgStop | input | 2 | Stop length |
| cfgMsbFirst | input | 1 | Assemble the data most significant bit first |
| cfgLineInvert | input | 1 | Invert the whole line |
| cfgDataInvert | input | 1 | Invert the data and parity bits only |
| evtValid | output | NUM_CH | Event present this cycle, per channel |
| evtKind | output | NUM_CH×3 | Event kind, per channel |
| evtChan | output | NUM_CH×CH_W | Channel tag, per channel |
| evtData | output | NUM_CH×DATA_W | Assembled data word |
| evtParExp | output | NUM_CH | Expected parity bit |
| evtParGot | output | NUM_CH | Received parity bit |

## Verification
On every cycle, the assertions check four things. A channel leaves idle only on a detected falling edge. The data-bit index stays below the configured width. The parity slot is skipped when parity is off. After an invalid start or any stop event, the channel is back in idle. They also check that the parity/parity-error choice agrees with the expected and received bits that go out with the event. Only the bench scenarios can show the rest: the exact sample timing, the word assembled for each width and bit order, the stop sample point for each stop length, the effect of both inversion options, and that the two channels stay independent.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;
  typedef enum logic [2:0] {
    EV_START = 3'd0, EV_DATA = 3'd1, EV_PARITY = 3'd2, EV_STOP = 3'd3,
    EV_BAD_START = 3'd4, EV_BAD_STOP = 3'd5, EV_PAR_ERR = 3'd6
  } evKind_e;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0, PAR_ODD = 3'd1, PAR_EVEN = 3'd2, PAR_MARK = 3'd3, PAR_SPACE = 3'd4
  } parMode_e;

  typedef enum logic [1:0] {
    STOP_HALF = 2'd0, STOP_ONE = 2'd1, STOP_ONEHALF = 2'd2
  } stopLen_e;

  typedef struct packed {
    logic loadStart;
    logic loadBit;
    logic loadStop;
    logic clearWord;
    logic shiftWord;
    logic takeParity;
  } ctlStb_t;
endpackage

// File: rtl/uart_mon_dp.sv
module uart_mon_dp
  import uart_mon_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineRaw,
  input  logic [CNT_W-1:0]  cfgBitPeriod,
  input  logic [3:0]        cfgDataBits,
  input  logic [2:0]        cfgParity,
  input  logic [1:0]        cfgStop,
  input  logic              cfgMsbFirst,
  input  logic              cfgLineInvert,
  input  logic              cfgDataInvert,
  input  ctlStb_t           stb,
  output logic              fallEdge,
  output logic              tick,
  output logic              lineLvl,
  output logic              dataBit,
  output logic [DATA_W-1:0] word,
  output logic              parExp,
  output logic              parGot
);
  logic [1:0]       syncQ;
  logic             prevLvl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfP;
  logic [CNT_W-1:0] quarterP;
  logic [CNT_W-1:0] stopOff;
  logic [DATA_W-1:0] lsbIns;

  // normalize polarity, then two synchronizer flops and an edge register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      prevLvl <= 1'b1;
    end else begin
      syncQ   <= {syncQ[0], lineRaw ^ cfgLineInvert};
      prevLvl <= syncQ[1];
    end
  end

  assign lineLvl  = syncQ[1];
  assign fallEdge = prevLvl & ~syncQ[1];
  assign dataBit  = syncQ[1] ^ cfgDataInvert;

  assign halfP    = cfgBitPeriod >> 1;
  assign quarterP = cfgBitPeriod >> 2;

  always_comb begin
    case (cfgStop)
      STOP_HALF:    stopOff = quarterP;
      STOP_ONEHALF: stopOff = halfP + quarterP;
      default:      stopOff = halfP;
    endcase
  end

  // distance counter to the next sample point
  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (stb.loadStart)  cnt <= halfP - 1'b1;
    else if (stb.loadBit)    cnt <= cfgBitPeriod - 1'b1;
    else if (stb.loadStop)   cnt <= halfP + stopOff - 1'b1;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);

  assign lsbIns = {{(DATA_W-1){1'b0}}, dataBit} << (cfgDataBits - 4'd1);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearWord) word <= '0;
    else if (stb.shiftWord)     word <= cfgMsbFirst ? {word[DATA_W-2:0], dataBit}
                                                    : ((word >> 1) | lsbIns);
  end

  always_ff @(posedge clk) begin
    if (!rstN)               parGot <= 1'b0;
    else if (stb.takeParity) parGot <= dataBit;
  end

  always_comb begin
    case (cfgParity)
      PAR_ODD:  parExp = ~(^word);
      PAR_EVEN: parExp = ^word;
      PAR_MARK: parExp = 1'b1;
      default:  parExp = 1'b0;
    endcase
  end
endmodule

// File: rtl/uart_mon_ctl.sv
module uart_mon_ctl
  import uart_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fallEdge,
  input  logic       tick,
  input  logic       lineLvl,
  input  logic       dataBit,
  input  logic       parExp,
  input  logic [3:0] cfgDataBits,
  input  logic [2:0] cfgParity,
  output ctlStb_t    stb,
  output logic       evtValid,
  output logic [2:0] evtKind
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PARITY, S_STOP} state_e;

  state_e     state, stNext;
  logic [3:0] bitIdx, idxNext;
  logic       evV;
  evKind_e    evK;
  logic       lastBit;

  assign lastBit = (bitIdx == cfgDataBits - 4'd1);

  always_comb begin
    stb     = '0;
    stNext  = state;
    idxNext = bitIdx;
    evV     = 1'b0;
    evK     = EV_START;
    case (state)
      S_IDLE: if (fallEdge) begin
        stNext = S_START;
        stb.loadStart = 1'b1;
      end
      S_START: if (tick) begin
        evV = 1'b1;
        if (!lineLvl) begin
          evK = EV_START;
          stNext = S_DATA;
          stb.loadBit = 1'b1;
          stb.clearWord = 1'b1;
          idxNext = '0;
        end else begin
          evK = EV_BAD_START;
          stNext = S_IDLE;
        end
      end
      S_DATA: if (tick) begin
        stb.shiftWord = 1'b1;
        if (lastBit) begin
          evV = 1'b1;
          evK = EV_DATA;
          if (cfgParity == PAR_NONE) begin
            stNext = S_STOP;
            stb.loadStop = 1'b1;
          end else begin
            stNext = S_PARITY;
            stb.loadBit = 1'b1;
          end
        end else begin
          idxNext = bitIdx + 4'd1;
          stb.loadBit = 1'b1;
        end
      end
      S_PARITY: if (tick) begin
        stb.takeParity = 1'b1;
        evV = 1'b1;
        evK = (dataBit == parExp) ? EV_PARITY : EV_PAR_ERR;
        stNext = S_STOP;
        stb.loadStop = 1'b1;
      end
      S_STOP: if (tick) begin
        evV = 1'b1;
        evK = lineLvl ? EV_STOP : EV_BAD_STOP;
        stNext = S_IDLE;
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitIdx   <= '0;
      evtValid <= 1'b0;
      evtKind  <= '0;
    end else begin
      state    <= stNext;
      bitIdx   <= idxNext;
      evtValid <= evV;
      evtKind  <= evK;
    end
  end

  AST_IDLE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !fallEdge) |=> (state == S_IDLE)); // R1
  AST_DATA_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA) |-> (bitIdx < cfgDataBits)); // R3
  AST_NO_PARITY_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgParity == PAR_NONE && state == S_DATA && tick && lastBit) |=> (state == S_STOP)); // R5
  AST_BAD_START_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == EV_BAD_START) |-> (state == S_IDLE)); // R6
  AST_STOP_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && (evtKind == EV_STOP || evtKind == EV_BAD_STOP)) |-> (state == S_IDLE)); // R7
endmodule

// File: rtl/uart_frame_monitor.sv
module uart_frame_monitor
  import uart_mon_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 9,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CH-1:0]              lineIn,
  input  logic [CNT_W-1:0]               cfgBitPeriod,
  input  logic [3:0]                     cfgDataBits,
  input  logic [2:0]                     cfgParity,
  input  logic [1:0]                     cfgStop,
  input  logic                           cfgMsbFirst,
  input  logic                           cfgLineInvert,
  input  logic                           cfgDataInvert,
  output logic [NUM_CH-1:0]              evtValid,
  output logic [NUM_CH-1:0][2:0]         evtKind,
  output logic [NUM_CH-1:0][CH_W-1:0]    evtChan,
  output logic [NUM_CH-1:0][DATA_W-1:0]  evtData,
  output logic [NUM_CH-1:0]              evtParExp,
  output logic [NUM_CH-1:0]              evtParGot
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    ctlStb_t stb;
    logic    fallEdge, tick, lineLvl, dataBit;

    uart_mon_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_dp (
      .clk(clk), .rstN(rstN), .lineRaw(lineIn[g]),
      .cfgBitPeriod(cfgBitPeriod), .cfgDataBits(cfgDataBits), .cfgParity(cfgParity),
      .cfgStop(cfgStop), .cfgMsbFirst(cfgMsbFirst), .cfgLineInvert(cfgLineInvert),
      .cfgDataInvert(cfgDataInvert), .stb(stb),
      .fallEdge(fallEdge), .tick(tick), .lineLvl(lineLvl), .dataBit(dataBit),
      .word(evtData[g]), .parExp(evtParExp[g]), .parGot(evtParGot[g])
    );

    uart_mon_ctl i_ctl (
      .clk(clk), .rstN(rstN), .fallEdge(fallEdge), .tick(tick), .lineLvl(lineLvl),
      .dataBit(dataBit), .parExp(evtParExp[g]), .cfgDataBits(cfgDataBits),
      .cfgParity(cfgParity), .stb(stb), .evtValid(evtValid[g]), .evtKind(evtKind[g])
    );

    assign evtChan[g] = CH_W'(g);

    AST_PARITY_AGREE: assert property (@(posedge clk) disable iff (!rstN)
      (evtValid[g] && evtKind[g] == EV_PARITY) |-> (evtParGot[g] == evtParExp[g])); // R4
    AST_PARITY_DIFFER: assert property (@(posedge clk) disable iff (!rstN)
      (evtValid[g] && evtKind[g] == EV_PAR_ERR) |-> (evtParGot[g] != evtParExp[g])); // R4
  end
endmodule

// File: tb/test_uart_frame_monitor.sv
`timescale 1ns/1ps
module test_uart_frame_monitor;
  typedef struct packed {
    logic [7:0] p;
    logic [3:0] nb;
    logic [2:0] par;
    logic [1:0] stp;
    logic       msb;
    logic       linv;
    logic       dinv;
    logic       badPar;
    logic [1:0] shape;   // 0 stop high, 1 low for first half of slot, 2 low whole slot
    logic       both;
    logic [8:0] word;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{8'd16, 4'd8, 3'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 9'h0A5}, // R2 R3 R12
    '{8'd16, 4'd8, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 9'h03C}, // R4 odd
    '{8'd16, 4'd8, 3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 9'h03D}, // R4 even
    '{8'd16, 4'd7, 3'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 9'h055}, // R4 mark
    '{8'd16, 4'd5, 3'd4, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 9'h013}, // R3 R4 space
    '{8'd16, 4'd9, 3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 9'h1A7}, // R3 width 9
    '{8'd16, 4'd8, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 9'h081}, // R4 odd error
    '{8'd16, 4'd8, 3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 9'h0F0}, // R4 even error
    '{8'd12, 4'd8, 3'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 9'h0C1}, // R9 R5
    '{8'd16, 4'd8, 3'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 9'h05A}, // R10
    '{8'd16, 4'd8, 3'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 9'h096}, // R11
    '{8'd16, 4'd8, 3'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 9'h0E7}, // R7 bad stop
    '{8'd16, 4'd8, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 9'h019}, // R8 half
    '{8'd16, 4'd8, 3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 9'h0C8}, // R8 one and half
    '{8'd20, 4'd6, 3'd3, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 9'h02B}  // R4 mark error
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  lineLog = 2'b11;
  logic [15:0] cfgBitPeriod = 16'd16;
  logic [3:0]  cfgDataBits = 4'd8;
  logic [2:0]  cfgParity = 3'd0;
  logic [1:0]  cfgStop = 2'd1;
  logic        cfgMsbFirst = 1'b0, cfgLineInvert = 1'b0, cfgDataInvert = 1'b0;
  logic [1:0]  lineIn;
  logic [1:0]       evtValid;
  logic [1:0][2:0]  evtKind;
  logic [1:0][0:0]  evtChan;
  logic [1:0][8:0]  evtData;
  logic [1:0]       evtParExp, evtParGot;

  assign lineIn = lineLog ^ {2{cfgLineInvert}};

  uart_frame_monitor i_uart_frame_monitor (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .cfgBitPeriod(cfgBitPeriod),
    .cfgDataBits(cfgDataBits), .cfgParity(cfgParity), .cfgStop(cfgStop),
    .cfgMsbFirst(cfgMsbFirst), .cfgLineInvert(cfgLineInvert), .cfgDataInvert(cfgDataInvert),
    .evtValid(evtValid), .evtKind(evtKind), .evtChan(evtChan), .evtData(evtData),
    .evtParExp(evtParExp), .evtParGot(evtParGot)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int evN [2];
  int evK [2][256];
  int evD [2][256];
  int evE [2][256];
  int evG [2][256];
  int evC [2][256];
  int evT [2][256];

  initial begin
    evN[0] = 0;
    evN[1] = 0;
  end

  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < 2; c++) begin
        if (evtValid[c] && evN[c] < 256) begin
          evK[c][evN[c]] = int'(evtKind[c]);
          evD[c][evN[c]] = int'(evtData[c]);
          evE[c][evN[c]] = int'(evtParExp[c]);
          evG[c][evN[c]] = int'(evtParGot[c]);
          evC[c][evN[c]] = int'(evtChan[c]);
          evT[c][evN[c]] = cyc;
          evN[c] = evN[c] + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic parOf(input logic [2:0] par, input logic [8:0] w);
    case (par)
      3'd1: return ~(^w);
      3'd2: return ^w;
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic put(input int ch, input logic lvl, input int n);
    lineLog[ch] = lvl;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendFrame(input int ch, input vec_t v, input logic [8:0] w, output int t0);
    int p = int'(v.p);
    logic pb;
    @(posedge clk);
    #1;
    t0 = cyc;
    put(ch, 1'b0, p);
    for (int i = 0; i < int'(v.nb); i++)
      put(ch, (v.msb ? w[int'(v.nb)-1-i] : w[i]) ^ v.dinv, p);
    if (v.par != 3'd0) begin
      pb = parOf(v.par, w) ^ v.badPar;
      put(ch, pb ^ v.dinv, p);
    end
    case (v.shape)
      2'd1: begin put(ch, 1'b0, p/2); put(ch, 1'b1, 2*p); end
      2'd2: begin put(ch, 1'b0, p); put(ch, 1'b1, 2*p); end
      default: put(ch, 1'b1, 2*p);
    endcase
  endtask

  task automatic checkFrame(input int ch, input vec_t v, input logic [8:0] w,
                            input int base, input int t0);
    int ek [4];
    int n = 0;
    int p = int'(v.p);
    int half = p / 2;
    int got;
    logic pe;
    pe = parOf(v.par, w);
    ek[n++] = 0;
    ek[n++] = 1;
    if (v.par != 3'd0) ek[n++] = v.badPar ? 6 : 2;
    if (v.shape == 2'd2 || (v.shape == 2'd1 && v.stp == 2'd0)) ek[n++] = 5;
    else ek[n++] = 3;
    got = evN[ch] - base;
    chk(got == n, "R1 event count", got, n);
    for (int i = 0; i < n && i < got; i++) begin
      chk(evK[ch][base+i] == ek[i], "R7 event kind", evK[ch][base+i], ek[i]);
      chk(evC[ch][base+i] == ch, "R12 channel tag", evC[ch][base+i], ch);
      if (ek[i] == 0)
        chk(evT[ch][base+i] == t0 + half + 3, "R2 start timing", evT[ch][base+i] - t0, half + 3);
      if (ek[i] == 1) begin
        chk(evD[ch][base+i] == int'(w), "R3 data word", evD[ch][base+i], int'(w));
        chk(evT[ch][base+i] == t0 + half + 3 + int'(v.nb) * p, "R2 data timing",
            evT[ch][base+i] - t0, half + 3 + int'(v.nb) * p);
      end
      if (ek[i] == 2 || ek[i] == 6) begin
        chk(evE[ch][base+i] == int'(pe), "R4 expected parity", evE[ch][base+i], int'(pe));
        chk(evG[ch][base+i] == int'(pe ^ v.badPar), "R4 received parity",
            evG[ch][base+i], int'(pe ^ v.badPar));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int b0, b1, t0a, t0b;
    logic [8:0] mask, w0, w1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(evtValid == 2'b00, "R1 reset quiet", int'(evtValid), 0);
    rstN = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(evN[0] == 0 && evN[1] == 0, "R1 idle quiet", evN[0] + evN[1], 0);

    // R6: a 3-cycle glitch gives an invalid start, and the next frame still decodes
    b0 = evN[0];
    @(posedge clk); #1;
    lineLog[0] = 1'b0;
    repeat (3) @(posedge clk); #1;
    lineLog[0] = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(evN[0] - b0 == 1, "R6 glitch event count", evN[0] - b0, 1);
    chk(evK[0][b0] == 4, "R6 invalid start kind", evK[0][b0], 4);

    for (int k = 0; k < NV; k++) begin
      vec_t v = VEC[k];
      cfgBitPeriod = 16'(v.p);
      cfgDataBits  = v.nb;
      cfgParity    = v.par;
      cfgStop      = v.stp;
      cfgMsbFirst  = v.msb;
      cfgLineInvert = v.linv;
      cfgDataInvert = v.dinv;
      mask = 9'((10'h1 << v.nb) - 10'h1);
      w0 = v.word & mask;
      w1 = ~v.word & mask;
      repeat (6) @(posedge clk);
      b0 = evN[0];
      b1 = evN[1];
      t0a = 0;
      t0b = 0;
      fork
        sendFrame(0, v, w0, t0a);
        begin
          if (v.both) sendFrame(1, v, w1, t0b);
        end
      join
      repeat (3 * int'(v.p)) @(posedge clk);
      @(negedge clk);
      checkFrame(0, v, w0, b0, t0a);
      if (v.both) checkFrame(1, v, w1, b1, t0b);
      else chk(evN[1] == b1, "R12 other channel silent", evN[1] - b1, 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule